// File: doc/BRIEF.md
# Buffer Descriptor Ring Controller

This block keeps the transmit and receive buffer descriptors of a simple Ethernet MAC and steps through them. A single table of two-word descriptors is split at a programmable boundary: entries below the boundary form the transmit ring and entries from the boundary upward form the receive ring. A CPU fills and inspects the table through a 32-bit register port. Word 0 of each entry holds control and status. Word 1 holds the buffer address.

The transmit walker waits on its current entry until software marks it ready. It then presents the buffer address, length and framing flags to the outgoing frame engine. When the engine reports completion, the walker writes the status back into the same entry. The receive walker offers its current entry to the incoming frame engine while that entry is marked empty, and writes back the received length and error flags when the frame ends. Both walkers follow a per-entry wrap flag to return to the start of their ring. Both emit single-cycle event pulses for an interrupt unit. The DMA and frame engines are modelled as simple handshakes.

Top module: `bdr_ring_ctrl`

## Requirements
- R1: After synchronous reset every descriptor word reads 0, the transmit-count register reads DEPTH/2 (64), `ev` is 0, and `tx_req` and `rx_ready` are low.
- R2: A CPU write with `cpu_addr` = 0x400 + 8*i writes word 0 of descriptor i, and 0x404 + 8*i writes word 1. Reads of those addresses return the stored words combinationally. The transmit-count register is at 0x020. Every other address reads 0.
- R3: A write to the transmit-count register stores min(value, DEPTH), so a write of 200 reads back 128. Transmit entries are indices 0..count-1 and receive entries are count..DEPTH-1.
- R4: With `tx_en` high, when the current transmit entry has word 0 bit 15 (ready) set, `tx_req` rises and holds until `tx_done`. While it is high, `tx_buf_addr` = word 1, `tx_len` = bits 31:16, `tx_pad` = bit 12 and `tx_crc` = bit 11. While the ready bit is clear, the walker stays on that entry and never skips to a later ready entry.
- R5: On `tx_done`, word 0 of the served entry becomes {length, bit 15 = 0, bits 14:9 unchanged, bits 8:0 = `tx_stat`}. In `tx_stat`, bit 8 is underrun, bits 7:4 are the retry count, bit 3 is retry limit, bit 2 is late collision, bit 1 is defer and bit 0 is carrier lost.
- R6: A transmit completion of an entry whose bit 14 (interrupt enable) is set pulses `ev[1]` when any of `tx_stat` bits 8, 3, 2 or 0 is set, and pulses `ev[0]` otherwise. An entry with bit 14 clear produces no event.
- R7: After serving an entry whose bit 13 (wrap) is set, or the last entry of its ring, a walker returns to the first entry of that ring. Otherwise it moves to the next index.
- R8: With `rx_en` high, `rx_ready` is high while the receive walker is idle and its current entry has bit 15 (empty) set. A `rx_frame` pulse while ready claims the entry, drops `rx_ready` and drives `rx_buf_addr` = word 1. On `rx_done`, word 0 becomes {`rx_len`, bit 15 = 0, bits 14:9 unchanged, bits 8:0 = `rx_stat`}.
- R9: A receive completion of an entry with bit 14 set pulses `ev[3]` when any of `rx_stat` bits 7:0 is set, and pulses `ev[2]` otherwise. Bit 8 (control frame) is not an error. With bit 14 clear there is no event.
- R10: A `rx_frame` pulse while `rx_en` is high and `rx_ready` is low pulses `ev[4]` (busy). The frame is dropped: no descriptor is written and the walker index does not change.
- R11: When `tx_en` is low, the transmit walker returns to entry 0 and `tx_req` drops. When `rx_en` is low, the receive walker returns to entry `count`.
- R12: Every event bit is a single-cycle pulse in the cycle after the clock edge that sampled the completion or the dropped frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tx_en | input | 1 | Transmit ring enable |
| rx_en | input | 1 | Receive ring enable |
| cpu_we | input | 1 | CPU write strobe |
| cpu_addr | input | 11 | CPU byte address |
| cpu_wdata | input | 32 | CPU write data |
| cpu_rdata | output | 32 | CPU read data (combinational) |
| tx_req | output | 1 | Transmit entry presented to the frame engine |
| tx_buf_addr | output | 32 | Transmit buffer address |
| tx_len | output | 16 | Transmit frame length |
| tx_pad | output | 1 | Pad short frame |
| tx_crc | output | 1 | Append FCS |
| tx_done | input | 1 | Transmit completion strobe |
| tx_stat | input | 9 | Transmit completion status |
| rx_ready | output | 1 | Empty receive entry available |
| rx_buf_addr | output | 32 | Receive buffer address of the claimed entry |
| rx_frame | input | 1 | Incoming frame start strobe |
| rx_done | input | 1 | Receive completion strobe |
| rx_len | input | 16 | Received length including FCS |
| rx_stat | input | 9 | Receive completion status |
| ev | output | 5 | Event pulses: 0 tx ok, 1 tx error, 2 rx ok, 3 rx error, 4 busy |

## Verification
Transmit descriptors are armed with random lengths, addresses, flags, wrap bits and interrupt enables, and completed with random status. Each presented address identifies which entry the walker took, so the wrap and last-entry rules are told apart. Receive frames use random error patterns, including the control-frame bit alone, to separate the error event from the normal event. Directed cases cover a stalled walker facing a later ready entry, a frame that arrives on a non-empty entry, a mid-frame disable, count saturation and unmapped reads.

// File: rtl/bdr_pkg.sv
package bdr_pkg;

    localparam int REG_AW = 11;
    localparam logic [REG_AW-1:0] CNT_REG_ADDR = 11'h020;

    localparam int EV_W      = 5;
    localparam int EV_TX_OK  = 0;
    localparam int EV_TX_ERR = 1;
    localparam int EV_RX_OK  = 2;
    localparam int EV_RX_ERR = 3;
    localparam int EV_BUSY   = 4;

    // Word 0 of a descriptor; own = ready (tx) or empty (rx).
    typedef struct packed {
        logic [15:0] len;
        logic        own;
        logic        irq;
        logic        wrap;
        logic        pad;
        logic        crc;
        logic [1:0]  rsvd;
        logic [8:0]  stat;
    } bd_ctl_t;

    typedef enum logic {WALK_IDLE, WALK_BUSY} walk_state_e;

    function automatic logic tx_failed(input logic [8:0] s);
        return s[8] | s[3] | s[2] | s[0];
    endfunction

    function automatic logic rx_failed(input logic [8:0] s);
        return |s[7:0];
    endfunction

    function automatic bd_ctl_t retire_bd(input bd_ctl_t c, input logic [15:0] len,
                                          input logic [8:0] s);
        bd_ctl_t r;
        r      = c;
        r.len  = len;
        r.own  = 1'b0;
        r.stat = s;
        return r;
    endfunction

endpackage

// File: rtl/bdr_table.sv
module bdr_table
    import bdr_pkg::*;
#(
    parameter int DEPTH = 128,
    parameter int IW    = 7,
    parameter int CW    = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cpu_we,
    input  logic [REG_AW-1:0] cpu_addr,
    input  logic [31:0]       cpu_wdata,
    output logic [31:0]       cpu_rdata,
    output logic [CW-1:0]     tx_count,
    input  logic [IW-1:0]     tx_idx,
    output logic [31:0]       tx_w0,
    output logic [31:0]       tx_w1,
    input  logic              tx_wb_en,
    input  logic [31:0]       tx_wb_data,
    input  logic [IW-1:0]     rx_idx,
    output logic [31:0]       rx_w0,
    output logic [31:0]       rx_w1,
    input  logic              rx_wb_en,
    input  logic [31:0]       rx_wb_data
);

    logic [31:0]   w0_q [DEPTH];
    logic [31:0]   w1_q [DEPTH];
    logic [CW-1:0] cnt_q;
    logic          desc_hit, cnt_hit;
    logic [IW-1:0] cpu_idx;
    logic [CW-1:0] cnt_next;

    assign desc_hit = cpu_addr[10] && ({1'b0, cpu_addr[9:3]} < 8'(DEPTH));
    assign cpu_idx  = cpu_addr[3 +: IW];
    assign cnt_hit  = (cpu_addr[REG_AW-1:2] == CNT_REG_ADDR[REG_AW-1:2]);
    assign cnt_next = (cpu_wdata > 32'(DEPTH)) ? CW'(DEPTH) : cpu_wdata[CW-1:0];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < DEPTH; i++) begin
                w0_q[i] <= '0;
                w1_q[i] <= '0;
            end
            cnt_q <= CW'(DEPTH / 2);
        end else begin
            if (cpu_we && desc_hit) begin
                if (cpu_addr[2]) w1_q[cpu_idx] <= cpu_wdata;
                else             w0_q[cpu_idx] <= cpu_wdata;
            end
            if (cpu_we && cnt_hit) cnt_q <= cnt_next;
            // walker write-backs land after the CPU write and win on a clash
            if (tx_wb_en) w0_q[tx_idx] <= tx_wb_data;
            if (rx_wb_en) w0_q[rx_idx] <= rx_wb_data;
        end
    end

    always_comb begin
        cpu_rdata = '0;
        if (desc_hit)     cpu_rdata = cpu_addr[2] ? w1_q[cpu_idx] : w0_q[cpu_idx];
        else if (cnt_hit) cpu_rdata = 32'(cnt_q);
    end

    assign tx_count = cnt_q;
    assign tx_w0    = w0_q[tx_idx];
    assign tx_w1    = w1_q[tx_idx];
    assign rx_w0    = w0_q[rx_idx];
    assign rx_w1    = w1_q[rx_idx];

    p_count_cap_r3: assert property (@(posedge clk) disable iff (rst)
        cnt_q <= CW'(DEPTH));

    p_count_write_r3: assert property (@(posedge clk) disable iff (rst)
        (cpu_we && cnt_hit && cpu_wdata > 32'(DEPTH)) |=> (cnt_q == CW'(DEPTH)));

endmodule

// File: rtl/bdr_tx_walk.sv
module bdr_tx_walk
    import bdr_pkg::*;
#(
    parameter int DEPTH = 128,
    parameter int IW    = 7,
    parameter int CW    = 8
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          en,
    input  logic [CW-1:0] count,
    input  logic [31:0]   w0,
    input  logic [31:0]   w1,
    output logic [IW-1:0] idx,
    output logic          req,
    output logic [31:0]   buf_addr,
    output logic [15:0]   len,
    output logic          pad,
    output logic          crc,
    input  logic          done,
    input  logic [8:0]    stat,
    output logic          wb_en,
    output logic [31:0]   wb_data,
    output logic          ev_ok,
    output logic          ev_err
);

    walk_state_e state_q;
    logic [IW-1:0] idx_q;
    bd_ctl_t       cur, ctl_q;
    logic [31:0]   addr_q;
    logic          in_ring, at_last, fail;

    assign cur     = bd_ctl_t'(w0);
    assign in_ring = CW'(idx_q) < count;
    assign at_last = (CW'(idx_q) + CW'(1)) == count;
    assign fail    = tx_failed(stat);

    always_ff @(posedge clk) begin
        if (rst || !en) begin
            state_q <= WALK_IDLE;
            idx_q   <= '0;
            ctl_q   <= '0;
            addr_q  <= '0;
            ev_ok   <= 1'b0;
            ev_err  <= 1'b0;
        end else begin
            ev_ok  <= 1'b0;
            ev_err <= 1'b0;
            case (state_q)
                WALK_IDLE: begin
                    if (!in_ring) begin
                        idx_q <= '0;
                    end else if (cur.own) begin
                        state_q <= WALK_BUSY;
                        ctl_q   <= cur;
                        addr_q  <= w1;
                    end
                end
                WALK_BUSY: begin
                    if (done) begin
                        state_q <= WALK_IDLE;
                        idx_q   <= (ctl_q.wrap || at_last) ? '0 : idx_q + IW'(1);
                        ev_ok   <= ctl_q.irq && !fail;
                        ev_err  <= ctl_q.irq && fail;
                    end
                end
                default: state_q <= WALK_IDLE;
            endcase
        end
    end

    assign idx      = idx_q;
    assign req      = (state_q == WALK_BUSY);
    assign buf_addr = addr_q;
    assign len      = ctl_q.len;
    assign pad      = ctl_q.pad;
    assign crc      = ctl_q.crc;
    assign wb_en    = en && req && done;
    assign wb_data  = retire_bd(ctl_q, ctl_q.len, stat);

    p_req_hold_r4: assert property (@(posedge clk) disable iff (rst)
        (req && !done && en) |=> req);

    p_stall_r4: assert property (@(posedge clk) disable iff (rst)
        (!req && en && !cur.own) |=> (!req && $stable(idx_q)));

    p_ev_excl_r6: assert property (@(posedge clk) disable iff (rst)
        !(ev_ok && ev_err));

    p_ev_cause_r12: assert property (@(posedge clk) disable iff (rst)
        (ev_ok || ev_err) |-> $past(done && req));

    p_home_r11: assert property (@(posedge clk) disable iff (rst)
        !en |=> (idx_q == '0 && !req));

endmodule

// File: rtl/bdr_rx_walk.sv
module bdr_rx_walk
    import bdr_pkg::*;
#(
    parameter int DEPTH = 128,
    parameter int IW    = 7,
    parameter int CW    = 8
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          en,
    input  logic [CW-1:0] count,
    input  logic [31:0]   w0,
    input  logic [31:0]   w1,
    output logic [IW-1:0] idx,
    output logic          ready,
    output logic [31:0]   buf_addr,
    input  logic          frame,
    input  logic          done,
    input  logic [15:0]   len,
    input  logic [8:0]    stat,
    output logic          wb_en,
    output logic [31:0]   wb_data,
    output logic          ev_ok,
    output logic          ev_err,
    output logic          ev_busy
);

    walk_state_e state_q;
    logic [CW-1:0] rel_q;
    logic [CW:0]   abs_w;
    logic [IW-1:0] abs_q;
    bd_ctl_t       cur, ctl_q;
    logic [31:0]   addr_q;
    logic          in_ring, at_last, fail;

    assign cur     = bd_ctl_t'(w0);
    assign abs_w   = {1'b0, count} + {1'b0, rel_q};
    assign in_ring = abs_w < (CW+1)'(DEPTH);
    assign at_last = abs_q == IW'(DEPTH - 1);
    assign fail    = rx_failed(stat);
    assign ready   = en && (state_q == WALK_IDLE) && in_ring && cur.own;

    always_ff @(posedge clk) begin
        if (rst || !en) begin
            state_q <= WALK_IDLE;
            rel_q   <= '0;
            abs_q   <= '0;
            ctl_q   <= '0;
            addr_q  <= '0;
            ev_ok   <= 1'b0;
            ev_err  <= 1'b0;
            ev_busy <= 1'b0;
        end else begin
            ev_ok   <= 1'b0;
            ev_err  <= 1'b0;
            ev_busy <= frame && !ready;
            case (state_q)
                WALK_IDLE: begin
                    if (!in_ring) begin
                        rel_q <= '0;
                    end else if (frame && ready) begin
                        state_q <= WALK_BUSY;
                        ctl_q   <= cur;
                        addr_q  <= w1;
                        abs_q   <= abs_w[IW-1:0];
                    end
                end
                WALK_BUSY: begin
                    if (done) begin
                        state_q <= WALK_IDLE;
                        rel_q   <= (ctl_q.wrap || at_last) ? '0 : rel_q + CW'(1);
                        ev_ok   <= ctl_q.irq && !fail;
                        ev_err  <= ctl_q.irq && fail;
                    end
                end
                default: state_q <= WALK_IDLE;
            endcase
        end
    end

    assign idx      = (state_q == WALK_BUSY) ? abs_q : abs_w[IW-1:0];
    assign buf_addr = addr_q;
    assign wb_en    = en && (state_q == WALK_BUSY) && done;
    assign wb_data  = retire_bd(ctl_q, len, stat);

    p_claim_hold_r8: assert property (@(posedge clk) disable iff (rst)
        (state_q == WALK_BUSY && !done && en) |=> (state_q == WALK_BUSY));

    p_rx_ev_excl_r9: assert property (@(posedge clk) disable iff (rst)
        !(ev_ok && ev_err));

    p_busy_cause_r10: assert property (@(posedge clk) disable iff (rst)
        ev_busy |-> $past(frame && en));

    p_busy_keeps_idx_r10: assert property (@(posedge clk) disable iff (rst)
        (frame && !ready && en && state_q == WALK_IDLE && in_ring) |=> (state_q == WALK_IDLE && $stable(rel_q)));

    p_rx_home_r11: assert property (@(posedge clk) disable iff (rst)
        !en |=> (rel_q == '0 && !ready));

endmodule

// File: rtl/bdr_ring_ctrl.sv
module bdr_ring_ctrl
    import bdr_pkg::*;
#(
    parameter int DEPTH = 128
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              tx_en,
    input  logic              rx_en,
    input  logic              cpu_we,
    input  logic [REG_AW-1:0] cpu_addr,
    input  logic [31:0]       cpu_wdata,
    output logic [31:0]       cpu_rdata,
    output logic              tx_req,
    output logic [31:0]       tx_buf_addr,
    output logic [15:0]       tx_len,
    output logic              tx_pad,
    output logic              tx_crc,
    input  logic              tx_done,
    input  logic [8:0]        tx_stat,
    output logic              rx_ready,
    output logic [31:0]       rx_buf_addr,
    input  logic              rx_frame,
    input  logic              rx_done,
    input  logic [15:0]       rx_len,
    input  logic [8:0]        rx_stat,
    output logic [EV_W-1:0]   ev
);

    localparam int IW = $clog2(DEPTH);
    localparam int CW = $clog2(DEPTH + 1);

    logic [CW-1:0] count;
    logic [IW-1:0] t_idx, r_idx;
    logic [31:0]   t_w0, t_w1, r_w0, r_w1, t_wb, r_wb;
    logic          t_wb_en, r_wb_en;
    logic          t_ok, t_err, r_ok, r_err, r_busy;

    bdr_table #(.DEPTH(DEPTH), .IW(IW), .CW(CW)) u_table (
        .clk(clk), .rst(rst),
        .cpu_we(cpu_we), .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata), .cpu_rdata(cpu_rdata),
        .tx_count(count),
        .tx_idx(t_idx), .tx_w0(t_w0), .tx_w1(t_w1), .tx_wb_en(t_wb_en), .tx_wb_data(t_wb),
        .rx_idx(r_idx), .rx_w0(r_w0), .rx_w1(r_w1), .rx_wb_en(r_wb_en), .rx_wb_data(r_wb)
    );

    bdr_tx_walk #(.DEPTH(DEPTH), .IW(IW), .CW(CW)) u_tx (
        .clk(clk), .rst(rst), .en(tx_en), .count(count),
        .w0(t_w0), .w1(t_w1), .idx(t_idx),
        .req(tx_req), .buf_addr(tx_buf_addr), .len(tx_len), .pad(tx_pad), .crc(tx_crc),
        .done(tx_done), .stat(tx_stat),
        .wb_en(t_wb_en), .wb_data(t_wb), .ev_ok(t_ok), .ev_err(t_err)
    );

    bdr_rx_walk #(.DEPTH(DEPTH), .IW(IW), .CW(CW)) u_rx (
        .clk(clk), .rst(rst), .en(rx_en), .count(count),
        .w0(r_w0), .w1(r_w1), .idx(r_idx),
        .ready(rx_ready), .buf_addr(rx_buf_addr),
        .frame(rx_frame), .done(rx_done), .len(rx_len), .stat(rx_stat),
        .wb_en(r_wb_en), .wb_data(r_wb), .ev_ok(r_ok), .ev_err(r_err), .ev_busy(r_busy)
    );

    always_comb begin
        ev            = '0;
        ev[EV_TX_OK]  = t_ok;
        ev[EV_TX_ERR] = t_err;
        ev[EV_RX_OK]  = r_ok;
        ev[EV_RX_ERR] = r_err;
        ev[EV_BUSY]   = r_busy;
    end

    p_ev_pulse_r12: assert property (@(posedge clk) disable iff (rst)
        (ev[EV_TX_OK] || ev[EV_TX_ERR]) |=> !(ev[EV_TX_OK] || ev[EV_TX_ERR]));

    p_rx_addr_r8: assert property (@(posedge clk) disable iff (rst)
        (rx_ready && rx_frame) |=> !rx_ready);

endmodule

// File: tb/test_bdr_ring_ctrl.sv
module test_bdr_ring_ctrl;

    localparam int DEPTH = 128;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        tx_en = 1'b0, rx_en = 1'b0;
    logic        cpu_we = 1'b0;
    logic [10:0] cpu_addr = '0;
    logic [31:0] cpu_wdata = '0;
    logic [31:0] cpu_rdata;
    logic        tx_req, tx_pad, tx_crc;
    logic [31:0] tx_buf_addr, rx_buf_addr;
    logic [15:0] tx_len;
    logic        tx_done = 1'b0;
    logic [8:0]  tx_stat = '0;
    logic        rx_ready;
    logic        rx_frame = 1'b0, rx_done = 1'b0;
    logic [15:0] rx_len = '0;
    logic [8:0]  rx_stat = '0;
    logic [4:0]  ev;

    int nvec = 0;
    int nbad = 0;
    int tcnt = 4;
    int t_exp = 0;
    int r_rel = 0;

    always #10 clk = ~clk;

    bdr_ring_ctrl #(.DEPTH(DEPTH)) i_bdr_ring_ctrl (
        .clk(clk), .rst(rst), .tx_en(tx_en), .rx_en(rx_en),
        .cpu_we(cpu_we), .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata), .cpu_rdata(cpu_rdata),
        .tx_req(tx_req), .tx_buf_addr(tx_buf_addr), .tx_len(tx_len), .tx_pad(tx_pad),
        .tx_crc(tx_crc), .tx_done(tx_done), .tx_stat(tx_stat),
        .rx_ready(rx_ready), .rx_buf_addr(rx_buf_addr), .rx_frame(rx_frame),
        .rx_done(rx_done), .rx_len(rx_len), .rx_stat(rx_stat), .ev(ev)
    );

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        nvec++;
        if (act !== exp) begin
            nbad++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    function automatic logic [10:0] bd_addr(input int i, input int w);
        return 11'(32'h400 + i * 8 + w * 4);
    endfunction

    function automatic logic [4:0] tx_ev(input logic irq, input logic [8:0] s);
        logic e;
        e = s[8] | s[3] | s[2] | s[0];
        return {3'b000, irq & e, irq & ~e};
    endfunction

    function automatic logic [4:0] rx_ev(input logic irq, input logic [8:0] s);
        logic e;
        e = |s[7:0];
        return {1'b0, irq & e, irq & ~e, 2'b00};
    endfunction

    function automatic logic [31:0] retired(input logic [31:0] w0, input logic [15:0] l,
                                            input logic [8:0] s);
        return {l, 1'b0, w0[14:9], s};
    endfunction

    task automatic wr(input logic [10:0] a, input logic [31:0] d);
        @(negedge clk);
        cpu_we = 1'b1; cpu_addr = a; cpu_wdata = d;
        @(negedge clk);
        cpu_we = 1'b0;
    endtask

    task automatic rd(input logic [10:0] a, output logic [31:0] d);
        cpu_addr = a;
        #1;
        d = cpu_rdata;
    endtask

    task automatic tx_one(input int i);
        logic [31:0] w0, w1, got;
        logic [8:0]  st;
        w1 = 32'hA000_0000 | (i << 16) | ($urandom & 32'hFFFF);
        w0 = {16'($urandom), 1'b1, 1'($urandom), ($urandom % 4 == 0), 4'($urandom), 9'($urandom)};
        wr(bd_addr(i, 1), w1);
        wr(bd_addr(i, 0), w0);
        for (int k = 0; k < 8 && !tx_req; k++) @(negedge clk);
        check("R4 tx_req", 32'(tx_req), 1);
        check("R7 tx entry order (addr)", tx_buf_addr, w1);
        check("R4 tx_len", 32'(tx_len), 32'(w0[31:16]));
        check("R4 tx_pad/crc", {30'b0, tx_pad, tx_crc}, {30'b0, w0[12], w0[11]});
        st = 9'($urandom);
        if ($urandom % 3 == 0) st = st & 9'h0F2;
        tx_done = 1'b1; tx_stat = st;
        @(negedge clk);
        tx_done = 1'b0;
        check("R6 tx event", 32'(ev), 32'(tx_ev(w0[14], st)));
        check("R4 tx_req drops", 32'(tx_req), 0);
        rd(bd_addr(i, 0), got);
        check("R5 tx writeback", got, retired(w0, w0[31:16], st));
        @(negedge clk);
        check("R12 tx event one cycle", 32'(ev), 0);
        t_exp = (w0[13] || i == tcnt - 1) ? 0 : i + 1;
    endtask

    task automatic rx_one();
        logic [31:0] w0, w1, got;
        logic [8:0]  st;
        logic [15:0] l;
        int a;
        a  = tcnt + r_rel;
        w1 = 32'hB000_0000 | (a << 16) | ($urandom & 32'hFFFF);
        w0 = {16'($urandom), 1'b1, 1'($urandom), ($urandom % 3 == 0), 4'($urandom), 9'($urandom)};
        wr(bd_addr(a, 1), w1);
        wr(bd_addr(a, 0), w0);
        check("R8 rx_ready on empty", 32'(rx_ready), 1);
        rx_frame = 1'b1;
        @(negedge clk);
        rx_frame = 1'b0;
        check("R8 rx claimed", 32'(rx_ready), 0);
        check("R7 rx entry order (addr)", rx_buf_addr, w1);
        case ($urandom % 3)
            0: st = 9'h000;
            1: st = 9'h100;
            default: st = 9'($urandom);
        endcase
        l = 16'($urandom);
        rx_done = 1'b1; rx_len = l; rx_stat = st;
        @(negedge clk);
        rx_done = 1'b0;
        check("R9 rx event", 32'(ev), 32'(rx_ev(w0[14], st)));
        rd(bd_addr(a, 0), got);
        check("R8 rx writeback", got, retired(w0, l, st));
        r_rel = (w0[13] || a == DEPTH - 1) ? 0 : r_rel + 1;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        nbad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", nvec, nbad);
        $finish;
    end

    initial begin
        logic [31:0] got, d;
        int idx;
        void'($urandom(32'd20240));
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);

        // R1 reset state
        rd(bd_addr(0, 0), got);  check("R1 desc word0", got, 0);
        rd(bd_addr(5, 1), got);  check("R1 desc word1", got, 0);
        rd(11'h020, got);        check("R1 tx count", got, 64);
        check("R1 ev", 32'(ev), 0);
        check("R1 tx_req/rx_ready", {30'b0, tx_req, rx_ready}, 0);

        // R3 saturation
        wr(11'h020, 32'd200);
        rd(11'h020, got);        check("R3 count saturates", got, 128);
        wr(11'h020, 32'h8000_0001);
        rd(11'h020, got);        check("R3 huge count saturates", got, 128);
        wr(11'h020, 32'd4);
        rd(11'h020, got);        check("R3 count 4", got, 4);

        // R2 register port
        rd(11'h024, got);        check("R2 unmapped read", got, 0);
        for (int k = 0; k < 16; k++) begin
            idx = 64 + ($urandom % 64);
            d   = $urandom;
            wr(bd_addr(idx, k % 2), d);
            rd(bd_addr(idx, k % 2), got);
            check("R2 descriptor readback", got, d);
        end

        tx_en = 1'b1;
        rx_en = 1'b1;

        for (int k = 0; k < 12; k++) tx_one(t_exp);

        // R4 stall: current entry not ready, a later entry ready
        idx = (t_exp + 1) % tcnt;
        wr(bd_addr(idx, 1), 32'hDEAD_0000);
        wr(bd_addr(idx, 0), 32'h0040_8000);
        wr(bd_addr(t_exp, 0), 32'h0010_0000);
        repeat (6) @(negedge clk);
        check("R4 stall no skip", 32'(tx_req), 0);
        wr(bd_addr(idx, 0), 32'h0);
        for (int k = 0; k < 6; k++) tx_one(t_exp);

        for (int k = 0; k < 16; k++) rx_one();

        // R10 busy: current entry not empty
        idx = tcnt + r_rel;
        wr(bd_addr(idx, 0), 32'h0123_4055);
        check("R10 not ready", 32'(rx_ready), 0);
        rx_frame = 1'b1;
        @(negedge clk);
        rx_frame = 1'b0;
        check("R10 busy event", 32'(ev), 32'h10);
        rd(bd_addr(idx, 0), got);
        check("R10 dropped frame no write", got, 32'h0123_4055);
        @(negedge clk);
        check("R12 busy one cycle", 32'(ev), 0);
        rx_one();

        // R11 transmit disable mid-frame
        if (t_exp == 0) tx_one(0);
        idx = t_exp;
        wr(bd_addr(idx, 1), 32'h5555_0000);
        wr(bd_addr(idx, 0), 32'h0020_8000);
        for (int k = 0; k < 8 && !tx_req; k++) @(negedge clk);
        check("R11 tx started", 32'(tx_req), 1);
        tx_en = 1'b0;
        @(negedge clk);
        check("R11 tx_req dropped", 32'(tx_req), 0);
        wr(bd_addr(idx, 0), 32'h0);
        tx_en = 1'b1;
        t_exp = 0;
        tx_one(t_exp);

        // R11 receive disable
        if (r_rel == 0) rx_one();
        rx_en = 1'b0;
        @(negedge clk);
        check("R11 rx_ready off", 32'(rx_ready), 0);
        rx_en = 1'b1;
        r_rel = 0;
        rx_one();
        for (int k = 0; k < 6; k++) rx_one();

        $display("== %0d vectors applied, %0d miscompares ==", nvec, nbad);
        $finish;
    end

endmodule